// File: doc/BRIEF.md
# Trap Entry Sequencer

This block steers a pipelined core through taking a trap, whether an asynchronous interrupt or a synchronous exception. It never cancels an instruction that has already issued. When a trap is accepted, the sequencer flushes the front of the pipeline that has not yet issued and sends fetch to the handler address. It then holds decode so that no new instruction issues. Next it waits for the in-flight count of issued instructions to reach zero. Only then does it strobe the trap CSR update and release decode.

An interrupt can be overtaken while the pipeline drains. If one of the draining instructions reports a fault, the trap being taken becomes that exception, and the CSR update carries the fault's cause. When an exception and an interrupt arrive together, the exception is taken. Once an interrupt has been accepted, the sequence always completes. A write that clears the global interrupt enable during the drain therefore cannot stall it.

Top module: `trap_seq_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, flush_o, redirect_o, hold_decode_o, csr_wr_o and trap_is_irq_o are all 0.
- R2: A trap accepted at a clock edge makes flush_o and redirect_o high for exactly the following cycle, with redirect_pc_o equal to the TRAP_VEC parameter in that cycle.
- R3: hold_decode_o is high from the flush cycle through the CSR update cycle, and is low in the cycle right after csr_wr_o.
- R4: csr_wr_o rises only in the cycle after an edge at which the sequencer was draining and inflight_cnt_i was 0. It never rises while issued instructions remain.
- R5: If exc_valid_i and an enabled irq_req_i are both high at the accepting edge, the exception is taken: trap_cause_o equals exc_cause_i and trap_is_irq_o is 0 at csr_wr_o.
- R6: irq_req_i is ignored while irq_en_i is 0 (no flush follows). When both are high it is accepted with trap_is_irq_o = 1 and cause irq_cause_i.
- R7: A post_exc_valid_i pulse during the drain of an interrupt turns the trap into an exception: at csr_wr_o, trap_is_irq_o is 0 and trap_cause_o equals post_exc_cause_i.
- R8: A post_exc_valid_i pulse during the drain of an exception has no effect: the original exception cause is reported at csr_wr_o.
- R9: Once an interrupt is accepted, dropping irq_en_i and irq_req_i during the drain does not stop the sequence. csr_wr_o still occurs once the count reaches 0.
- R10: New exc_valid_i or irq_req_i requests arriving while a trap is in progress start no second flush. Exactly one csr_wr_o pulse is produced per accepted trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid_i | input | 1 | Exception reported by a just-issued instruction |
| exc_cause_i | input | CAUSE_W | Cause of that exception |
| irq_req_i | input | 1 | Pending interrupt request |
| irq_en_i | input | 1 | Global interrupt enable |
| irq_cause_i | input | CAUSE_W | Cause of the pending interrupt |
| inflight_cnt_i | input | CNT_W | Number of issued, not yet completed instructions |
| post_exc_valid_i | input | 1 | Fault raised by an instruction during the drain |
| post_exc_cause_i | input | CAUSE_W | Cause of that fault |
| flush_o | output | 1 | Flush all not-yet-issued instructions |
| redirect_o | output | 1 | Redirect the fetch PC |
| redirect_pc_o | output | PC_W | Handler address while redirect_o is high, otherwise 0 |
| hold_decode_o | output | 1 | Stall decode so that nothing issues |
| csr_wr_o | output | 1 | One-cycle strobe to record the trap in the CSRs |
| trap_cause_o | output | CAUSE_W | Cause of the trap being taken |
| trap_is_irq_o | output | 1 | 1 when the trap being taken is an interrupt |

## Verification
On every cycle, the assertions check the pulse shape of the flush, and that hold covers the flush and CSR update cycles. They also check that the CSR strobe follows a zero in-flight count, and that decode is released right after the strobe. Only the bench scenarios can show which cause and trap kind reach the CSR update. That covers exception-over-interrupt priority, conversion of an interrupt by a draining fault, a fault ignored during an exception drain, and completion after the enable drops. The scenarios also show that requests arriving during a trap are ignored.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  typedef enum logic [2:0] {
    TS_IDLE   = 3'd0,
    TS_FLUSH  = 3'd1,
    TS_DRAIN  = 3'd2,
    TS_CSR    = 3'd3,
    TS_RESUME = 3'd4
  } trap_state_e;
endpackage

// File: rtl/trap_seq_arb.sv
// Picks the trap to take when the sequencer is idle; exceptions win.
module trap_seq_arb #(
  parameter int CAUSE_W = 5
) (
  input  logic               exc_valid_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic               irq_req_i,
  input  logic               irq_en_i,
  input  logic [CAUSE_W-1:0] irq_cause_i,
  output logic               take_o,
  output logic               take_irq_o,
  output logic [CAUSE_W-1:0] take_cause_o
);
  logic irq_live;

  always_comb begin
    irq_live     = irq_req_i & irq_en_i;
    take_o       = exc_valid_i | irq_live;
    take_irq_o   = ~exc_valid_i & irq_live;
    take_cause_o = exc_valid_i ? exc_cause_i : irq_cause_i;
  end
endmodule

// File: rtl/trap_seq_fsm.sv
// Sequencer state and the latched trap cause / kind.
module trap_seq_fsm
  import trap_seq_pkg::*;
#(
  parameter int CAUSE_W = 5,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take_i,
  input  logic               take_irq_i,
  input  logic [CAUSE_W-1:0] take_cause_i,
  input  logic [CNT_W-1:0]   inflight_cnt_i,
  input  logic               post_exc_valid_i,
  input  logic [CAUSE_W-1:0] post_exc_cause_i,
  output trap_state_e        state_n_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               is_irq_o
);
  trap_state_e        state_q, state_n;
  logic [CAUSE_W-1:0] cause_q, cause_n;
  logic               irq_q, irq_n;
  logic               drained;
  logic               convert;

  always_comb begin
    drained = (inflight_cnt_i == '0);
    convert = post_exc_valid_i & irq_q;
    state_n = state_q;
    cause_n = cause_q;
    irq_n   = irq_q;
    unique case (state_q)
      TS_IDLE: begin
        if (take_i) begin
          state_n = TS_FLUSH;
          cause_n = take_cause_i;
          irq_n   = take_irq_i;
        end
      end
      TS_FLUSH: state_n = TS_DRAIN;
      TS_DRAIN: begin
        if (convert) begin
          // a draining instruction faulted: take it as an exception instead
          cause_n = post_exc_cause_i;
          irq_n   = 1'b0;
        end else if (drained) begin
          state_n = TS_CSR;
        end
      end
      TS_CSR:    state_n = TS_RESUME;
      TS_RESUME: state_n = TS_IDLE;
      default:   state_n = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TS_IDLE;
      cause_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cause_q <= cause_n;
      irq_q   <= irq_n;
    end
  end

  assign state_n_o = state_n;
  assign cause_o   = cause_q;
  assign is_irq_o  = irq_q;
endmodule

// File: rtl/trap_seq_outreg.sv
// Registers the pipeline control strobes from the next state.
module trap_seq_outreg
  import trap_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  trap_state_e state_n_i,
  output logic        flush_o,
  output logic        redirect_o,
  output logic        hold_o,
  output logic        csr_wr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flush_o    <= 1'b0;
      redirect_o <= 1'b0;
      hold_o     <= 1'b0;
      csr_wr_o   <= 1'b0;
    end else begin
      flush_o    <= (state_n_i == TS_FLUSH);
      redirect_o <= (state_n_i == TS_FLUSH);
      hold_o     <= (state_n_i == TS_FLUSH) || (state_n_i == TS_DRAIN) ||
                    (state_n_i == TS_CSR);
      csr_wr_o   <= (state_n_i == TS_CSR);
    end
  end
endmodule

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
  import trap_seq_pkg::*;
#(
  parameter int              CAUSE_W  = 5,
  parameter int              CNT_W    = 4,
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] TRAP_VEC = 32'h0000_0100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exc_valid_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic               irq_req_i,
  input  logic               irq_en_i,
  input  logic [CAUSE_W-1:0] irq_cause_i,
  input  logic [CNT_W-1:0]   inflight_cnt_i,
  input  logic               post_exc_valid_i,
  input  logic [CAUSE_W-1:0] post_exc_cause_i,
  output logic               flush_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o,
  output logic               hold_decode_o,
  output logic               csr_wr_o,
  output logic [CAUSE_W-1:0] trap_cause_o,
  output logic               trap_is_irq_o
);
  logic               take;
  logic               take_irq;
  logic [CAUSE_W-1:0] take_cause;
  trap_state_e        state_n;

  trap_seq_arb #(.CAUSE_W(CAUSE_W)) u_arb (
    .exc_valid_i (exc_valid_i),
    .exc_cause_i (exc_cause_i),
    .irq_req_i   (irq_req_i),
    .irq_en_i    (irq_en_i),
    .irq_cause_i (irq_cause_i),
    .take_o      (take),
    .take_irq_o  (take_irq),
    .take_cause_o(take_cause)
  );

  trap_seq_fsm #(.CAUSE_W(CAUSE_W), .CNT_W(CNT_W)) u_fsm (
    .clk             (clk),
    .rst             (rst),
    .take_i          (take),
    .take_irq_i      (take_irq),
    .take_cause_i    (take_cause),
    .inflight_cnt_i  (inflight_cnt_i),
    .post_exc_valid_i(post_exc_valid_i),
    .post_exc_cause_i(post_exc_cause_i),
    .state_n_o       (state_n),
    .cause_o         (trap_cause_o),
    .is_irq_o        (trap_is_irq_o)
  );

  trap_seq_outreg u_out (
    .clk       (clk),
    .rst       (rst),
    .state_n_i (state_n),
    .flush_o   (flush_o),
    .redirect_o(redirect_o),
    .hold_o    (hold_decode_o),
    .csr_wr_o  (csr_wr_o)
  );

  assign redirect_pc_o = redirect_o ? TRAP_VEC : '0;

  // R2: the flush is a single-cycle pulse
  a_r2_flush_pulse: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> !flush_o);
  // R3: decode is held while the flush is in progress
  a_r3_hold_in_flush: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> hold_decode_o);
  // R3: decode is held during the CSR update and released just after
  a_r3_hold_in_csr: assert property (@(posedge clk) disable iff (rst)
    csr_wr_o |-> hold_decode_o);
  a_r3_release_after_csr: assert property (@(posedge clk) disable iff (rst)
    csr_wr_o |=> !hold_decode_o);
  // R4: CSR update only after the in-flight count was seen at zero
  a_r4_csr_after_drain: assert property (@(posedge clk) disable iff (rst)
    $rose(csr_wr_o) |-> $past(inflight_cnt_i == '0));
  // R10: one CSR strobe per trap
  a_r10_single_csr: assert property (@(posedge clk) disable iff (rst)
    csr_wr_o |=> !csr_wr_o);
endmodule

// File: tb/trap_seq_ctrl_tb.sv
module trap_seq_ctrl_tb;
  localparam int CW = 5;
  localparam int NW = 4;
  localparam int PW = 32;
  localparam logic [PW-1:0] VEC = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exc_valid = 0, irq_req = 0, irq_en = 0, post_exc = 0;
  logic [CW-1:0] exc_cause = '0, irq_cause = '0, post_cause = '0;
  logic [NW-1:0] cnt = '0;
  logic flush, redirect, hold, csr_wr, is_irq;
  logic [PW-1:0] rpc;
  logic [CW-1:0] cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [CW:0] exp_q[$];   // {is_irq, cause}

  always #5 clk = ~clk;

  trap_seq_ctrl #(.CAUSE_W(CW), .CNT_W(NW), .PC_W(PW), .TRAP_VEC(VEC)) u_dut (
    .clk(clk), .rst(rst),
    .exc_valid_i(exc_valid), .exc_cause_i(exc_cause),
    .irq_req_i(irq_req), .irq_en_i(irq_en), .irq_cause_i(irq_cause),
    .inflight_cnt_i(cnt),
    .post_exc_valid_i(post_exc), .post_exc_cause_i(post_cause),
    .flush_o(flush), .redirect_o(redirect), .redirect_pc_o(rpc),
    .hold_decode_o(hold), .csr_wr_o(csr_wr),
    .trap_cause_o(cause), .trap_is_irq_o(is_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // monitor: compare every CSR update against the scoreboard
  always @(negedge clk) begin
    if (!rst && csr_wr) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10: actual csr_wr with cause %0h expected none", cause);
      end else begin
        logic [CW:0] e;
        e = exp_q.pop_front();
        chk("R5/R6/R7/R8/R9 trap kind and cause", {is_irq, cause}, e);
      end
    end
  end

  // wait for the CSR strobe, then confirm decode is released
  task automatic finish(input string req);
    int n = 0;
    while (!csr_wr && n < 50) begin step(); n++; end
    chk({req, " csr_wr seen"}, csr_wr, 1);
    chk("R3 hold during csr", hold, 1);
    step();
    chk("R3 hold released", hold, 0);
    step();
  endtask

  initial begin
    step(); step();
    chk("R1 flush in reset", flush, 0);
    chk("R1 hold in reset", hold, 0);
    rst = 1'b0;
    step();
    chk("R1 outputs after reset", {flush, redirect, hold, csr_wr, is_irq}, 0);

    // R2/R3/R4: exception with instructions still draining
    exc_valid = 1; exc_cause = 5'd2; cnt = 4'd2;
    exp_q.push_back({1'b0, 5'd2});
    step(); exc_valid = 0;
    chk("R2 flush", flush, 1);
    chk("R2 redirect", redirect, 1);
    chk("R2 redirect pc", rpc, VEC);
    chk("R3 hold at flush", hold, 1);
    step();
    chk("R2 flush single cycle", flush, 0);
    chk("R3 hold in drain", hold, 1);
    cnt = 4'd1; step();
    chk("R4 no csr while busy", csr_wr, 0);
    step();
    chk("R4 no csr while busy", csr_wr, 0);
    cnt = 4'd0; step();
    chk("R4 csr after drain", csr_wr, 1);
    finish("R4");

    // R6: interrupt ignored while disabled, then taken
    irq_req = 1; irq_cause = 5'd7; irq_en = 0;
    step(); step(); step();
    chk("R6 ignored when disabled", flush | hold, 0);
    irq_en = 1; exp_q.push_back({1'b1, 5'd7});
    step(); irq_req = 0;
    chk("R6 irq flush", flush, 1);
    finish("R6");

    // R5: simultaneous exception and interrupt
    irq_req = 1; irq_cause = 5'd11; exc_valid = 1; exc_cause = 5'd3;
    exp_q.push_back({1'b0, 5'd3});
    step(); irq_req = 0; exc_valid = 0;
    chk("R5 flush", flush, 1);
    finish("R5");

    // R7: draining fault converts an interrupt
    irq_req = 1; irq_cause = 5'd7; cnt = 4'd3;
    exp_q.push_back({1'b0, 5'd13});
    step(); irq_req = 0; step();
    post_exc = 1; post_cause = 5'd13; step(); post_exc = 0;
    chk("R7 kind switched", is_irq, 0);
    cnt = 4'd0;
    finish("R7");

    // R8: draining fault ignored on an exception
    exc_valid = 1; exc_cause = 5'd4; cnt = 4'd2;
    exp_q.push_back({1'b0, 5'd4});
    step(); exc_valid = 0; step();
    post_exc = 1; post_cause = 5'd9; step(); post_exc = 0;
    chk("R8 cause kept", cause, 5'd4);
    cnt = 4'd0;
    finish("R8");

    // R9: enable dropped during drain
    irq_req = 1; irq_cause = 5'd5; cnt = 4'd2;
    exp_q.push_back({1'b1, 5'd5});
    step(); irq_req = 0; irq_en = 0; step(); step();
    chk("R9 still holding", hold, 1);
    cnt = 4'd0;
    finish("R9");

    // R10: new requests during a trap are ignored
    irq_en = 1; exc_valid = 1; exc_cause = 5'd6; cnt = 4'd1;
    exp_q.push_back({1'b0, 5'd6});
    step(); step();
    irq_req = 1; irq_cause = 5'd1;
    step();
    chk("R10 no second flush", flush, 0);
    chk("R10 cause unchanged", cause, 5'd6);
    exc_valid = 0; irq_req = 0; cnt = 4'd0;
    finish("R10");
    step(); step();
    chk("R10 no extra trap", flush | csr_wr, 0);
    chk("R10 scoreboard drained", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule